// File: doc/BRIEF.md
# Serial port control and status register bank

This block is the software-visible register bank of a 16550-class serial port. It sits on a simple synchronous bus. Each register occupies a 4-byte word and only the low 16 bits carry data. The bank holds the baud divisor, frame-format control, modem control, global control, a scratch word and the interrupt enables. It also keeps line status and modem status, which build up from event strobes and level inputs supplied by an external transmitter and receiver.

Interrupt enables change only through two dedicated addresses: one that sets bits and one that clears them. No read-modify-write is needed. Error flags and the clear-to-send change flag stay set until software writes a one to them. When a new event arrives in the same cycle as a clearing write, the event wins. A single registered interrupt request combines every enabled source. The shifters, the baud generator and the FIFOs are outside this block.

Top module: `serial_csr_bank`

## Requirements
- R1: After reset the divisor reads 0x0001. All control, scratch and enable registers read 0. Line status reads 0x60, meaning holding-empty (bit 5) and transmitter-empty (bit 6) are set. Modem status reads 0.
- R2: The low byte written at 0x00 and the low byte written at 0x04 form the 16-bit `divisor` output as {byte at 0x04, byte at 0x00}. The line control word at 0x0C drives these outputs: word length (length−5) from bits 1:0, extra stop from bit 2, parity enable from bit 3, even parity from bit 4, stick parity from bit 5, and break from bit 6. Each register reads back what was written to it.
- R3: A write to 0x20 ORs the written bits into the enable register. A write to 0x24 clears the bits written as 1. Reading 0x20 returns the enables. Only bits 0, 1, 2, 3, 5 and 6 exist, so the mask is 0x6F.
- R4: `rts_out` is high whenever modem control (0x10) bit 1 or bit 6 is set. `uart_en` follows global control (0x08) bit 0.
- R5: A strobe on overrun, parity, framing or break sets line status bit 1, 2, 3 or 4 respectively. Each bit stays set until a write to 0x14 with that bit set to 1. Bits written as 0 are unchanged.
- R6: An event strobe in the same cycle as a write that clears its bit leaves the bit set.
- R7: A rising edge on `tsr_empty` sets line status bit 7 (transmission finished). A write of 1 to bit 7 clears it. Bits 0, 5 and 6 follow `rx_ready`, `thr_empty` and `tsr_empty` one cycle late.
- R8: Modem status (0x18) bit 4 is `cts_in` after a two-flop synchronizer. Bit 0 sets on any change of the synchronized level and is cleared only by writing 1 to bit 0. A change in the clearing cycle wins.
- R9: `irq` is registered, one cycle after the state that causes it. It is the OR of five terms: enable bit 0 with data ready, bit 1 with holding-empty, bit 2 with any of status bits 1–4, bit 3 with the modem-status change flag, and bit 5 with transmission finished.
- R10: Read data appears on `bus_rdata` one cycle after `bus_re` and holds until the next read. Unmapped or misaligned addresses read 0, and writes to them change nothing.
- R11: A write to 0x28 pulses `tx_load` for one cycle with `tx_byte` set to the low byte. A read of 0x2C returns `rx_byte` and pulses `rx_pop` for one cycle. The write-only addresses 0x24 and 0x28 read 0.
- R12: The scratch word at 0x1C stores and returns all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rx_ready | input | 1 | Receiver holds data (level) |
| thr_empty | input | 1 | Holding register empty (level) |
| tsr_empty | input | 1 | Holding and shift registers empty (level) |
| evt_overrun | input | 1 | Overrun strobe |
| evt_parity | input | 1 | Parity error strobe |
| evt_framing | input | 1 | Framing error strobe |
| evt_break | input | 1 | Break strobe |
| rx_byte | input | 8 | Received byte |
| cts_in | input | 1 | Asynchronous clear-to-send |
| divisor | output | 16 | Baud divisor |
| word_len | output | 2 | Word length minus 5 |
| stop_extra | output | 1 | Extra stop bit |
| parity_en | output | 1 | Parity enable |
| parity_even | output | 1 | Even parity |
| parity_stick | output | 1 | Stick parity |
| send_break | output | 1 | Force break |
| modem_ctrl | output | 8 | Modem control word |
| rts_out | output | 1 | Request to send |
| global_ctrl | output | 6 | Global control word |
| uart_en | output | 1 | Port clock enable |
| tx_load | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| rx_pop | output | 1 | Receive byte consumed strobe |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take four things for granted about the environment. The event strobes and read/write strobes are synchronous to `clk`. A cycle carries at most one bus address, so the set and clear enable addresses never act together. `tsr_empty` and `cts_in` hold steady through reset. The CTS-change and finish-edge properties also rely on reset being released before any edge is counted. The stimulus drives every input on the falling edge, keeps `cts_in` low and `tsr_empty` high during reset, and holds each CTS level for several cycles so that every change passes fully through the synchronizer.

// File: rtl/serial_csr_pkg.sv
package serial_csr_pkg;

  typedef enum logic [3:0] {
    SEL_DIV_LO  = 4'd0,
    SEL_DIV_HI  = 4'd1,
    SEL_GLOBAL  = 4'd2,
    SEL_LINE    = 4'd3,
    SEL_MODEM   = 4'd4,
    SEL_LSTAT   = 4'd5,
    SEL_MSTAT   = 4'd6,
    SEL_SCRATCH = 4'd7,
    SEL_IEN_SET = 4'd8,
    SEL_IEN_CLR = 4'd9,
    SEL_TXHOLD  = 4'd10,
    SEL_RXBUF   = 4'd11
  } csr_sel_e;

  localparam int IEN_W    = 7;
  localparam logic [IEN_W-1:0] IEN_MASK = 7'h6F;
  localparam int LINE_W   = 7;
  localparam int GLOBAL_W = 6;
  localparam int LSTAT_W  = 8;

  // line status bit positions
  localparam int LS_DR   = 0;
  localparam int LS_OVR  = 1;
  localparam int LS_PAR  = 2;
  localparam int LS_FRM  = 3;
  localparam int LS_BRK  = 4;
  localparam int LS_THRE = 5;
  localparam int LS_TEMT = 6;
  localparam int LS_FIN  = 7;

  // modem status bit positions
  localparam int MS_CHG = 0;
  localparam int MS_LVL = 4;

endpackage

// File: rtl/csr_cts_monitor.sv
module csr_cts_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cts_async,
  input  logic clr_req,
  output logic cts_level,
  output logic cts_changed
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   chg_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= cts_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], cts_async};
      end
    end
  endgenerate

  assign cts_level = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      last_q <= cts_level;
      chg_q  <= (cts_level ^ last_q) | (chg_q & ~clr_req);
    end
  end

  assign cts_changed = chg_q;

  // R8: a change of the synchronized level is always caught
  p_cts_change_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(cts_level)) |=> cts_changed);

  // R8: flag holds until cleared
  p_cts_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (cts_changed && !clr_req) |=> cts_changed);

endmodule

// File: rtl/csr_line_status.sv
module csr_line_status
  import serial_csr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_ready,
  input  logic               thr_empty,
  input  logic               tsr_empty,
  input  logic               evt_overrun,
  input  logic               evt_parity,
  input  logic               evt_framing,
  input  logic               evt_break,
  input  logic               w1c_valid,
  input  logic [LSTAT_W-1:0] w1c_mask,
  output logic [LSTAT_W-1:0] lstat
);
  logic dr_q, thre_q, temt_q, fin_q;
  logic [3:0] err_q;
  logic [3:0] err_evt;
  logic [3:0] err_clr;

  assign err_evt = {evt_break, evt_framing, evt_parity, evt_overrun};
  assign err_clr = w1c_valid ? w1c_mask[LS_BRK:LS_OVR] : 4'b0000;

  always_ff @(posedge clk) begin
    if (rst) begin
      dr_q   <= 1'b0;
      thre_q <= 1'b1;
      temt_q <= 1'b1;
      fin_q  <= 1'b0;
      err_q  <= '0;
    end else begin
      dr_q   <= rx_ready;
      thre_q <= thr_empty;
      temt_q <= tsr_empty;
      err_q  <= err_evt | (err_q & ~err_clr);
      fin_q  <= (tsr_empty & ~temt_q) |
                (fin_q & ~(w1c_valid & w1c_mask[LS_FIN]));
    end
  end

  always_comb begin
    lstat                     = '0;
    lstat[LS_DR]              = dr_q;
    lstat[LS_BRK:LS_OVR]      = err_q;
    lstat[LS_THRE]            = thre_q;
    lstat[LS_TEMT]            = temt_q;
    lstat[LS_FIN]             = fin_q;
  end

  // R5: an overrun flag survives any write that does not clear it
  p_err_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (lstat[LS_OVR] && !(w1c_valid && w1c_mask[LS_OVR])) |=> lstat[LS_OVR]);

  // R6: an event beats a clearing write in the same cycle
  p_evt_wins_r6: assert property (@(posedge clk) disable iff (rst)
    evt_break |=> lstat[LS_BRK]);

  // R7: a finish edge raises the finished flag
  p_fin_rise_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(tsr_empty)) |=> lstat[LS_FIN]);

endmodule

// File: rtl/csr_irq_gen.sv
module csr_irq_gen #(
  parameter int N_SRC = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] src_act,
  output logic             irq
);
  logic [N_SRC-1:0] hit;

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign hit[i] = src_en[i] & src_act[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |hit;
  end

endmodule

// File: rtl/serial_csr_bank.sv
module serial_csr_bank
  import serial_csr_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_ready,
  input  logic              thr_empty,
  input  logic              tsr_empty,
  input  logic              evt_overrun,
  input  logic              evt_parity,
  input  logic              evt_framing,
  input  logic              evt_break,
  input  logic [7:0]        rx_byte,
  input  logic              cts_in,
  output logic [15:0]       divisor,
  output logic [1:0]        word_len,
  output logic              stop_extra,
  output logic              parity_en,
  output logic              parity_even,
  output logic              parity_stick,
  output logic              send_break,
  output logic [7:0]        modem_ctrl,
  output logic              rts_out,
  output logic [5:0]        global_ctrl,
  output logic              uart_en,
  output logic              tx_load,
  output logic [7:0]        tx_byte,
  output logic              rx_pop,
  output logic              irq
);
  localparam int N_IRQ = 5;

  logic              addr_hi_ok;
  logic              addr_ok;
  logic              wr_hit;
  logic              rd_hit;
  csr_sel_e          sel;

  logic [7:0]          div_lo_q, div_hi_q;
  logic [GLOBAL_W-1:0] global_q;
  logic [LINE_W-1:0]   line_q;
  logic [7:0]          modem_q;
  logic [DATA_W-1:0]   scratch_q;
  logic [IEN_W-1:0]    ien_q;
  logic [LSTAT_W-1:0]  lstat;
  logic                cts_level, cts_changed;
  logic [DATA_W-1:0]   rd_mux;
  logic                ien_set_wr, ien_clr_wr;
  logic [N_IRQ-1:0]    irq_en, irq_act;

  generate
    if (ADDR_W > 6) begin : g_hi
      assign addr_hi_ok = (bus_addr[ADDR_W-1:6] == '0);
    end else begin : g_nohi
      assign addr_hi_ok = 1'b1;
    end
  endgenerate

  assign addr_ok    = addr_hi_ok & (bus_addr[1:0] == 2'b00);
  assign sel        = csr_sel_e'(bus_addr[5:2]);
  assign wr_hit     = bus_we & addr_ok;
  assign rd_hit     = bus_re & addr_ok;
  assign ien_set_wr = wr_hit & (sel == SEL_IEN_SET);
  assign ien_clr_wr = wr_hit & (sel == SEL_IEN_CLR);

  // writable registers
  always_ff @(posedge clk) begin
    if (rst) begin
      div_lo_q  <= 8'h01;
      div_hi_q  <= 8'h00;
      global_q  <= '0;
      line_q    <= '0;
      modem_q   <= '0;
      scratch_q <= '0;
      ien_q     <= '0;
    end else if (wr_hit) begin
      case (sel)
        SEL_DIV_LO:  div_lo_q  <= bus_wdata[7:0];
        SEL_DIV_HI:  div_hi_q  <= bus_wdata[7:0];
        SEL_GLOBAL:  global_q  <= bus_wdata[GLOBAL_W-1:0];
        SEL_LINE:    line_q    <= bus_wdata[LINE_W-1:0];
        SEL_MODEM:   modem_q   <= bus_wdata[7:0];
        SEL_SCRATCH: scratch_q <= bus_wdata;
        SEL_IEN_SET: ien_q     <= (ien_q | bus_wdata[IEN_W-1:0]) & IEN_MASK;
        SEL_IEN_CLR: ien_q     <= ien_q & ~bus_wdata[IEN_W-1:0];
        default:     ;
      endcase
    end
  end

  // transmit / receive side strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_load <= 1'b0;
      tx_byte <= '0;
      rx_pop  <= 1'b0;
    end else begin
      tx_load <= wr_hit & (sel == SEL_TXHOLD);
      if (wr_hit && sel == SEL_TXHOLD) tx_byte <= bus_wdata[7:0];
      rx_pop  <= rd_hit & (sel == SEL_RXBUF);
    end
  end

  csr_line_status u_lstat (
    .clk         (clk),
    .rst         (rst),
    .rx_ready    (rx_ready),
    .thr_empty   (thr_empty),
    .tsr_empty   (tsr_empty),
    .evt_overrun (evt_overrun),
    .evt_parity  (evt_parity),
    .evt_framing (evt_framing),
    .evt_break   (evt_break),
    .w1c_valid   (wr_hit & (sel == SEL_LSTAT)),
    .w1c_mask    (bus_wdata[LSTAT_W-1:0]),
    .lstat       (lstat)
  );

  csr_cts_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk         (clk),
    .rst         (rst),
    .cts_async   (cts_in),
    .clr_req     (wr_hit & (sel == SEL_MSTAT) & bus_wdata[MS_CHG]),
    .cts_level   (cts_level),
    .cts_changed (cts_changed)
  );

  assign irq_en  = {ien_q[5], ien_q[3], ien_q[2], ien_q[1], ien_q[0]};
  assign irq_act = {lstat[LS_FIN], cts_changed, |lstat[LS_BRK:LS_OVR],
                    lstat[LS_THRE], lstat[LS_DR]};

  csr_irq_gen #(.N_SRC(N_IRQ)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .src_en  (irq_en),
    .src_act (irq_act),
    .irq     (irq)
  );

  // read path
  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_DIV_LO:  rd_mux = DATA_W'(div_lo_q);
      SEL_DIV_HI:  rd_mux = DATA_W'(div_hi_q);
      SEL_GLOBAL:  rd_mux = DATA_W'(global_q);
      SEL_LINE:    rd_mux = DATA_W'(line_q);
      SEL_MODEM:   rd_mux = DATA_W'(modem_q);
      SEL_LSTAT:   rd_mux = DATA_W'(lstat);
      SEL_MSTAT: begin
        rd_mux[MS_CHG] = cts_changed;
        rd_mux[MS_LVL] = cts_level;
      end
      SEL_SCRATCH: rd_mux = scratch_q;
      SEL_IEN_SET: rd_mux = DATA_W'(ien_q);
      SEL_RXBUF:   rd_mux = DATA_W'(rx_byte);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= addr_ok ? rd_mux : '0;
  end

  assign divisor      = {div_hi_q, div_lo_q};
  assign word_len     = line_q[1:0];
  assign stop_extra   = line_q[2];
  assign parity_en    = line_q[3];
  assign parity_even  = line_q[4];
  assign parity_stick = line_q[5];
  assign send_break   = line_q[6];
  assign modem_ctrl   = modem_q;
  assign rts_out      = modem_q[1] | modem_q[6];
  assign global_ctrl  = global_q;
  assign uart_en      = global_q[0];

  // R3: set address leaves every written legal bit on
  p_ien_set_r3: assert property (@(posedge clk) disable iff (rst)
    ien_set_wr |=> ((ien_q & $past(bus_wdata[IEN_W-1:0] & IEN_MASK)) ==
                    $past(bus_wdata[IEN_W-1:0] & IEN_MASK)));

  // R3: clear address leaves every written bit off
  p_ien_clr_r3: assert property (@(posedge clk) disable iff (rst)
    ien_clr_wr |=> ((ien_q & $past(bus_wdata[IEN_W-1:0])) == '0));

  // R9: no enables, no request
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0) |=> !irq);

  // R10: read data holds without a read
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));

  // R11: transmit strobe is a single cycle
  p_tx_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    (tx_load && !$past(wr_hit && sel == SEL_TXHOLD)) |-> 1'b0);

endmodule

// File: tb/serial_csr_bank_bench.sv
`timescale 1ns/1ps
module serial_csr_bank_bench;
  localparam logic [5:0] A_DLO = 6'h00, A_DHI = 6'h04, A_GCTL = 6'h08,
    A_LINE = 6'h0C, A_MDM = 6'h10, A_LST = 6'h14, A_MST = 6'h18,
    A_SCR = 6'h1C, A_ISET = 6'h20, A_ICLR = 6'h24, A_TX = 6'h28,
    A_RX = 6'h2C;

  logic clk = 0, rst = 1;
  logic [5:0] bus_addr = 0;
  logic bus_we = 0, bus_re = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic rx_ready = 0, thr_empty = 1, tsr_empty = 1;
  logic evt_overrun = 0, evt_parity = 0, evt_framing = 0, evt_break = 0;
  logic [7:0] rx_byte = 8'h5A;
  logic cts_in = 0;
  logic [15:0] divisor;
  logic [1:0] word_len;
  logic stop_extra, parity_en, parity_even, parity_stick, send_break;
  logic [7:0] modem_ctrl, tx_byte;
  logic rts_out, uart_en, tx_load, rx_pop, irq;
  logic [5:0] global_ctrl;

  int n_run = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  logic re_d = 0;

  always #2 clk = ~clk;

  serial_csr_bank u_serial_csr_bank (.*);

  always @(posedge clk) re_d <= bus_re;

  // monitor: pop expected read data
  always @(negedge clk) begin
    if (re_d && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk(input string t, input logic [15:0] act, input logic [15:0] e);
    n_run++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got=%h expected=%h", t, act, e);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] e, input string t);
    @(negedge clk); bus_addr = a; bus_re = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_re = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    idle(2);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got=timeout expected=done");
    finish_run();
  end

  initial begin
    idle(4);
    rst = 0;
    // R1 reset state
    chk("R1 divisor", divisor, 16'h0001);
    chk("R1 irq", {15'd0, irq}, 16'h0);
    chk("R1 rts", {15'd0, rts_out}, 16'h0);
    rd(A_LST, 16'h0060, "R1 lstat");
    rd(A_ISET, 16'h0000, "R1 enables");
    rd(A_MST, 16'h0000, "R1 mstat");
    rd(A_LINE, 16'h0000, "R1 line");

    // R2 divisor and line fields
    wr(A_DLO, 16'h0034); wr(A_DHI, 16'h0012);
    chk("R2 divisor", divisor, 16'h1234);
    rd(A_DLO, 16'h0034, "R2 div lo");
    wr(A_LINE, 16'h005E);
    chk("R2 fields", {9'd0, send_break, parity_stick, parity_even, parity_en,
        stop_extra, word_len}, 16'h005E);
    rd(A_LINE, 16'h005E, "R2 line rb");

    // R4 rts and enable
    wr(A_MDM, 16'h0002); chk("R4 manual rts", {15'd0, rts_out}, 16'h1);
    wr(A_MDM, 16'h0040); chk("R4 auto rts", {15'd0, rts_out}, 16'h1);
    wr(A_MDM, 16'h0000); chk("R4 rts off", {15'd0, rts_out}, 16'h0);
    wr(A_GCTL, 16'h0001); chk("R4 uart_en", {15'd0, uart_en}, 16'h1);
    rd(A_GCTL, 16'h0001, "R4 gctl rb");

    // R12 scratch
    wr(A_SCR, 16'hBEEF); rd(A_SCR, 16'hBEEF, "R12 scratch");

    // R3 enables
    wr(A_ISET, 16'h0005); rd(A_ISET, 16'h0005, "R3 set");
    wr(A_ISET, 16'h0022); rd(A_ISET, 16'h0027, "R3 or");
    wr(A_ICLR, 16'h0004); rd(A_ISET, 16'h0023, "R3 clr");
    wr(A_ISET, 16'hFFFF); rd(A_ISET, 16'h006F, "R3 mask");
    wr(A_ICLR, 16'hFFFF); rd(A_ISET, 16'h0000, "R3 clr all");

    // R5 sticky errors
    @(negedge clk); evt_overrun = 1; @(negedge clk); evt_overrun = 0;
    rd(A_LST, 16'h0062, "R5 overrun");
    @(negedge clk); evt_parity = 1; evt_framing = 1;
    @(negedge clk); evt_parity = 0; evt_framing = 0;
    rd(A_LST, 16'h006E, "R5 three");
    wr(A_LST, 16'h0000); rd(A_LST, 16'h006E, "R5 zero write");
    wr(A_LST, 16'h0002); rd(A_LST, 16'h006C, "R5 w1c one");
    wr(A_LST, 16'h00FF); rd(A_LST, 16'h0060, "R5 w1c all");

    // R6 event wins
    @(negedge clk); evt_break = 1; bus_addr = A_LST; bus_wdata = 16'h00FF; bus_we = 1;
    @(negedge clk); evt_break = 0; bus_we = 0;
    rd(A_LST, 16'h0070, "R6 break kept");
    wr(A_LST, 16'h0010); rd(A_LST, 16'h0060, "R6 cleared");

    // R7 finished flag
    @(negedge clk); tsr_empty = 0; idle(2);
    rd(A_LST, 16'h0020, "R7 busy");
    tsr_empty = 1; idle(2);
    rd(A_LST, 16'h00E0, "R7 finished");
    wr(A_LST, 16'h0080); rd(A_LST, 16'h0060, "R7 cleared");

    // R8 cts
    cts_in = 1; idle(5);
    rd(A_MST, 16'h0011, "R8 rise");
    wr(A_MST, 16'h0000); rd(A_MST, 16'h0011, "R8 zero write");
    wr(A_MST, 16'h0001); rd(A_MST, 16'h0010, "R8 clear");
    cts_in = 0; idle(5);
    rd(A_MST, 16'h0001, "R8 fall");
    wr(A_MST, 16'h0001); rd(A_MST, 16'h0000, "R8 clear2");

    // R9 interrupts
    rx_ready = 1; idle(3);
    chk("R9 masked", {15'd0, irq}, 16'h0);
    wr(A_ISET, 16'h0001); @(negedge clk);
    chk("R9 data ready", {15'd0, irq}, 16'h1);
    // R11 receive read
    rd(A_RX, 16'h005A, "R11 rx byte");
    chk("R11 rx_pop", {15'd0, rx_pop}, 16'h1);
    @(negedge clk); chk("R11 rx_pop end", {15'd0, rx_pop}, 16'h0);
    rx_ready = 0; wr(A_ICLR, 16'h0001); idle(2);
    chk("R9 off", {15'd0, irq}, 16'h0);
    wr(A_ISET, 16'h0004);
    @(negedge clk); evt_framing = 1; @(negedge clk); evt_framing = 0; @(negedge clk);
    chk("R9 line status", {15'd0, irq}, 16'h1);
    wr(A_LST, 16'h0008); idle(1);
    chk("R9 line cleared", {15'd0, irq}, 16'h0);
    wr(A_ICLR, 16'h0004); wr(A_ISET, 16'h0008);
    cts_in = 1; idle(5);
    chk("R9 modem", {15'd0, irq}, 16'h1);
    wr(A_MST, 16'h0001); idle(1);
    chk("R9 modem cleared", {15'd0, irq}, 16'h0);
    wr(A_ICLR, 16'h0008); wr(A_ISET, 16'h0002); @(negedge clk);
    chk("R9 thre", {15'd0, irq}, 16'h1);
    wr(A_ICLR, 16'h0002);

    // R10 unmapped, misaligned, hold
    rd(6'h30, 16'h0000, "R10 unmapped");
    wr(6'h1D, 16'h1111); rd(A_SCR, 16'hBEEF, "R10 misaligned");
    idle(3); chk("R10 hold", bus_rdata, 16'hBEEF);

    // R11 transmit
    wr(A_TX, 16'h00A5);
    chk("R11 tx_load", {7'd0, tx_load, tx_byte}, 16'h01A5);
    @(negedge clk); chk("R11 tx_load end", {15'd0, tx_load}, 16'h0);
    rd(A_TX, 16'h0000, "R11 tx reads 0");

    finish_run();
  end
endmodule